// File: doc/BRIEF.md
# Single-Cycle Reduced-Instruction Processor Core

A 32-bit processor core that completes one instruction every clock cycle. Each cycle it presents the program counter on a fetch port and receives the instruction word combinationally. It reads two registers named by the instruction and computes a result in an ALU. In the same cycle it may read or write a separate data memory. At the clock edge it updates the program counter, the register file and (for stores) the data memory. Both memories sit outside the core as combinational-read, clock-write arrays.

The supported set has four parts: word load and store, register-register arithmetic and logic (add, addu, sub, subu, and, or, xor, nor, slt, sltu), the immediate forms (addi, addiu, andi, ori, xori, slti, sltiu), an equality branch and an absolute jump. Overflow never traps: add and sub behave like their unsigned twins. Any other opcode or function code executes as a no-op that only advances the program counter.

Top module: `cpu_core`

## Requirements
- R1: While the synchronous active-high reset is sampled high at a rising edge, the program counter becomes RESET_PC (default 0), and imem_addr always equals the program counter.
- R2: An instruction that is not a taken branch or a jump advances the program counter by 4 at the next edge.
- R3: With opcode 0x00, the function codes 0x20/0x21 (add), 0x22/0x23 (subtract), 0x24 (and), 0x25 (or), 0x26 (xor) and 0x27 (nor) combine the rs and rt values. The result goes to the register in bits [15:11], modulo 2^32.
- R4: Function codes 0x2A and 0x2B write 1 to the register in bits [15:11] when rs is less than rt, compared as signed values for 0x2A and as unsigned values for 0x2B. Otherwise they write 0.
- R5: Opcodes 0x08/0x09 (add), 0x0A (signed less-than) and 0x0B (unsigned less-than) sign-extend the 16-bit immediate in bits [15:0]. They write the result to the register in bits [20:16].
- R6: Opcodes 0x0C (and), 0x0D (or) and 0x0E (xor) zero-extend the immediate and write the result to the register in bits [20:16].
- R7: Opcode 0x23 loads the data word at address rs + sign-extended immediate into the register in bits [20:16].
- R8: Opcode 0x2B raises dmem_we for that cycle only. It writes the rt value to address rs + sign-extended immediate and changes no register.
- R9: Opcode 0x04 compares rs and rt. When they are equal, the next PC is PC + 4 + (sign-extended immediate << 2). Otherwise the next PC is PC + 4.
- R10: Opcode 0x02 sets the next PC to the upper 4 bits of PC + 4, followed by bits [25:0] of the instruction, followed by two zero bits.
- R11: Register 0 always reads as zero, and writes aimed at it are discarded.
- R12: Any other opcode, and opcode 0x00 with any other function code, changes neither a register nor data memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Fetch byte address (program counter) |
| imem_data | input | 32 | Instruction word at imem_addr, combinational |
| dmem_addr | output | 32 | Data byte address (ALU result) |
| dmem_wdata | output | 32 | Store data (rt value) |
| dmem_we | output | 1 | Store strobe, written at the next rising edge |
| dmem_rdata | input | 32 | Data word at dmem_addr, combinational |

## Verification
The bench builds the core with its defaults: a reset vector of zero and the full 32-entry register file. It attaches 256-word instruction and data memories, so every address the programs touch falls in a small window. That small setting makes a near-exhaustive sweep practical. Every register-register function and every immediate opcode runs across all 64 pairings of eight corner operands, with extreme signed and unsigned values on both sides, and each result is stored out through the data port and compared with arithmetic done in the bench. A directed program covers the rest: negative load offsets, the register-zero behaviour, taken and not-taken branches, the jump and undefined encodings. A recorded fetch-address trace confirms the program-counter sequence.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam int unsigned XLEN   = 32;
    localparam int unsigned RIDX_W = 5;
    localparam int unsigned NREGS  = 1 << RIDX_W;
    localparam int unsigned IMM_W  = 16;
    localparam int unsigned TGT_W  = 26;

    // primary opcodes
    localparam logic [5:0] OP_SPECIAL = 6'h00;
    localparam logic [5:0] OP_JUMP    = 6'h02;
    localparam logic [5:0] OP_BEQ     = 6'h04;
    localparam logic [5:0] OP_ADDI    = 6'h08;
    localparam logic [5:0] OP_ADDIU   = 6'h09;
    localparam logic [5:0] OP_SLTI    = 6'h0A;
    localparam logic [5:0] OP_SLTIU   = 6'h0B;
    localparam logic [5:0] OP_ANDI    = 6'h0C;
    localparam logic [5:0] OP_ORI     = 6'h0D;
    localparam logic [5:0] OP_XORI    = 6'h0E;
    localparam logic [5:0] OP_LOAD    = 6'h23;
    localparam logic [5:0] OP_STORE   = 6'h2B;

    // function codes under OP_SPECIAL
    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_ADDU = 6'h21;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_SUBU = 6'h23;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_XOR  = 6'h26;
    localparam logic [5:0] FN_NOR  = 6'h27;
    localparam logic [5:0] FN_SLT  = 6'h2A;
    localparam logic [5:0] FN_SLTU = 6'h2B;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_SLT, ALU_SLTU
    } alu_op_e;

    typedef enum logic [1:0] {
        PC_SEQ, PC_BEQ, PC_JMP
    } pc_sel_e;

    // register-format overlay of an instruction word
    typedef struct packed {
        logic [5:0]        op;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rd;
        logic [4:0]        shamt;
        logic [5:0]        funct;
    } instr_t;

    typedef struct packed {
        logic    reg_we;
        logic    dst_is_rd;
        logic    src_imm;
        logic    imm_zero;
        logic    load;
        logic    store;
        alu_op_e alu_op;
        pc_sel_e pc_sel;
    } ctrl_t;

    function automatic logic [XLEN-1:0] widen_imm(input logic [IMM_W-1:0] imm,
                                                  input logic zero_ext);
        logic fill;
        fill = zero_ext ? 1'b0 : imm[IMM_W-1];
        return {{(XLEN-IMM_W){fill}}, imm};
    endfunction

endpackage

// File: rtl/cpu_decode.sv
module cpu_decode
    import cpu_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '0;
        ctrl.alu_op = ALU_ADD;
        ctrl.pc_sel = PC_SEQ;
        case (op)
            OP_SPECIAL: begin
                ctrl.reg_we    = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                case (funct)
                    FN_ADD, FN_ADDU: ctrl.alu_op = ALU_ADD;
                    FN_SUB, FN_SUBU: ctrl.alu_op = ALU_SUB;
                    FN_AND:          ctrl.alu_op = ALU_AND;
                    FN_OR:           ctrl.alu_op = ALU_OR;
                    FN_XOR:          ctrl.alu_op = ALU_XOR;
                    FN_NOR:          ctrl.alu_op = ALU_NOR;
                    FN_SLT:          ctrl.alu_op = ALU_SLT;
                    FN_SLTU:         ctrl.alu_op = ALU_SLTU;
                    default:         ctrl.reg_we = 1'b0;
                endcase
            end
            OP_ADDI, OP_ADDIU: begin
                ctrl.reg_we  = 1'b1;
                ctrl.src_imm = 1'b1;
            end
            OP_SLTI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.alu_op  = ALU_SLT;
            end
            OP_SLTIU: begin
                ctrl.reg_we  = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.alu_op  = ALU_SLTU;
            end
            OP_ANDI, OP_ORI, OP_XORI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.src_imm  = 1'b1;
                ctrl.imm_zero = 1'b1;
                ctrl.alu_op   = (op == OP_ANDI) ? ALU_AND :
                                (op == OP_ORI)  ? ALU_OR  : ALU_XOR;
            end
            OP_LOAD: begin
                ctrl.reg_we  = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.load    = 1'b1;
            end
            OP_STORE: begin
                ctrl.src_imm = 1'b1;
                ctrl.store   = 1'b1;
            end
            OP_BEQ: begin
                ctrl.alu_op = ALU_SUB;
                ctrl.pc_sel = PC_BEQ;
            end
            OP_JUMP: ctrl.pc_sel = PC_JMP;
            default: ;
        endcase
    end

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
    import cpu_pkg::*;
#(
    parameter int unsigned WIDTH = XLEN,
    parameter int unsigned DEPTH = NREGS,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    ra,
    input  logic [AW-1:0]    rb,
    input  logic             we,
    input  logic [AW-1:0]    wa,
    input  logic [WIDTH-1:0] wd,
    output logic [WIDTH-1:0] qa,
    output logic [WIDTH-1:0] qb
);

    logic [WIDTH-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign qa = (ra == '0) ? '0 : regs[ra];
    assign qb = (rb == '0) ? '0 : regs[rb];

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int unsigned WIDTH = XLEN
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output logic             zero
);

    always_comb begin
        case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_XOR:  y = a ^ b;
            ALU_NOR:  y = ~(a | b);
            ALU_SLT:  y = {{(WIDTH-1){1'b0}}, $signed(a) < $signed(b)};
            ALU_SLTU: y = {{(WIDTH-1){1'b0}}, a < b};
            default:  y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/cpu_core.sv
module cpu_core
    import cpu_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_data,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    instr_t            ins;
    ctrl_t             ctrl;
    logic [XLEN-1:0]   pc_q, pc_next, pc_plus4, br_tgt, jmp_tgt;
    logic [XLEN-1:0]   rs_val, rt_val, imm_ext, alu_b, alu_y, wb_data;
    logic [RIDX_W-1:0] wb_idx;
    logic              alu_zero;

    assign ins = instr_t'(imem_data);

    cpu_decode u_dec (
        .op    (ins.op),
        .funct (ins.funct),
        .ctrl  (ctrl)
    );

    cpu_regfile #(.WIDTH(XLEN), .DEPTH(NREGS)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra  (ins.rs),
        .rb  (ins.rt),
        .we  (ctrl.reg_we),
        .wa  (wb_idx),
        .wd  (wb_data),
        .qa  (rs_val),
        .qb  (rt_val)
    );

    assign imm_ext = widen_imm(imem_data[IMM_W-1:0], ctrl.imm_zero);
    assign alu_b   = ctrl.src_imm ? imm_ext : rt_val;

    cpu_alu #(.WIDTH(XLEN)) u_alu (
        .op   (ctrl.alu_op),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign wb_idx  = ctrl.dst_is_rd ? ins.rd : ins.rt;
    assign wb_data = ctrl.load ? dmem_rdata : alu_y;

    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.store;

    // next-address logic
    assign pc_plus4 = pc_q + STEP;
    assign br_tgt   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_tgt  = {pc_plus4[XLEN-1:TGT_W+2], imem_data[TGT_W-1:0], 2'b00};

    always_comb begin
        case (ctrl.pc_sel)
            PC_BEQ:  pc_next = alu_zero ? br_tgt : pc_plus4;
            PC_JMP:  pc_next = jmp_tgt;
            default: pc_next = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_PC;
        else     pc_q <= pc_next;
    end

    assign imem_addr = pc_q;

endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk
    import cpu_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] imem_addr,
    input logic [XLEN-1:0] imem_data,
    input logic            dmem_we,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val
);

    logic [5:0]      opc;
    logic [XLEN-1:0] seq_pc, br_pc, j_pc;

    assign opc    = imem_data[31:26];
    assign seq_pc = imem_addr + 32'd4;
    assign br_pc  = seq_pc + {{14{imem_data[15]}}, imem_data[15:0], 2'b00};
    assign j_pc   = {seq_pc[31:28], imem_data[25:0], 2'b00};

    // R1
    assert_pc_reset_R1: assert property (@(posedge clk)
        rst |=> imem_addr == 32'd0);

    // R2
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (opc != OP_BEQ && opc != OP_JUMP) |=> imem_addr == $past(seq_pc));

    // R9
    assert_branch_taken_R9: assert property (@(posedge clk) disable iff (rst)
        (opc == OP_BEQ && rs_val == rt_val) |=> imem_addr == $past(br_pc));

    assert_branch_fall_R9: assert property (@(posedge clk) disable iff (rst)
        (opc == OP_BEQ && rs_val != rt_val) |=> imem_addr == $past(seq_pc));

    // R10
    assert_jump_target_R10: assert property (@(posedge clk) disable iff (rst)
        (opc == OP_JUMP) |=> imem_addr == $past(j_pc));

    // R8 / R12
    assert_store_only_R8: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> opc == OP_STORE);

    // R11
    assert_zero_reg_R11: assert property (@(posedge clk) disable iff (rst)
        (imem_data[25:21] == 5'd0) |-> rs_val == '0);

endmodule

bind cpu_core cpu_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .dmem_we   (dmem_we),
    .rs_val    (rs_val),
    .rt_val    (rt_val)
);

// File: tb/cpu_core_bench.sv
`timescale 1ns/100ps
module cpu_core_bench;
    import cpu_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [256];
    logic [31:0] dmem [256];
    logic [31:0] trace [32];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cpu_core u_cpu_core (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_data  = imem[imem_addr[9:2]];
    assign dmem_rdata = dmem[dmem_addr[9:2]];

    always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

    logic [31:0] opnd [8] = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                              32'h8000_0000, 32'h0000_0005, 32'h1234_5678, 32'hFFFF_0000};
    logic [15:0] imms [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000,
                              16'h7FFF, 16'h1234, 16'hFF00, 16'h0005};
    logic [5:0] fns [10] = '{FN_ADD, FN_ADDU, FN_SUB, FN_SUBU, FN_AND,
                             FN_OR, FN_XOR, FN_NOR, FN_SLT, FN_SLTU};
    logic [5:0] iops [7] = '{OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU, OP_ANDI, OP_ORI, OP_XORI};

    function automatic logic [31:0] f_r(logic [5:0] fn, int rs, int rt, int rd);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] f_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] f_j(int idx);
        return {OP_JUMP, 26'(idx)};
    endfunction

    function automatic logic [31:0] exp_r(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
        case (fn)
            FN_ADD, FN_ADDU: return a + b;
            FN_SUB, FN_SUBU: return a - b;
            FN_AND:          return a & b;
            FN_OR:           return a | b;
            FN_XOR:          return a ^ b;
            FN_NOR:          return ~(a | b);
            FN_SLT:          return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default:         return (a < b) ? 32'd1 : 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] exp_i(logic [5:0] op, logic [31:0] a, logic [15:0] imm);
        logic [31:0] s, z;
        s = {{16{imm[15]}}, imm};
        z = {16'h0000, imm};
        case (op)
            OP_ADDI, OP_ADDIU: return a + s;
            OP_SLTI:           return ($signed(a) < $signed(s)) ? 32'd1 : 32'd0;
            OP_SLTIU:          return (a < s) ? 32'd1 : 32'd0;
            OP_ANDI:           return a & z;
            OP_ORI:            return a | z;
            default:           return a ^ z;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // every unused word is a jump to itself
    task automatic clear_mem();
        for (int k = 0; k < 256; k++) begin
            imem[k] = f_j(k);
            dmem[k] = 32'h5A5A_0000 | 32'(k);
        end
        for (int k = 0; k < 8; k++) dmem[k] = opnd[k];
    endtask

    task automatic run(int cycles);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 reset pc", imem_addr, 32'd0);
        rst = 1'b0;
        trace[0] = imem_addr;
        for (int c = 1; c < cycles; c++) begin
            @(negedge clk);
            if (c < 32) trace[c] = imem_addr;
        end
    endtask

    task automatic load_operands(inout int p);
        for (int k = 0; k < 8; k++) imem[p++] = f_i(OP_LOAD, 0, 1 + k, 16'(4 * k));
    endtask

    initial begin
        int p;
        // R3 / R4 sweep
        foreach (fns[f]) begin
            clear_mem();
            p = 0;
            load_operands(p);
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++) begin
                    imem[p++] = f_r(fns[f], 1 + i, 1 + j, 9);
                    imem[p++] = f_i(OP_STORE, 0, 9, 16'(64 + 4 * (i * 8 + j)));
                end
            run(p + 6);
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    chk((fns[f] == FN_SLT || fns[f] == FN_SLTU) ? "R4 compare" : "R3 reg op",
                        dmem[16 + i * 8 + j], exp_r(fns[f], opnd[i], opnd[j]));
        end
        // R5 / R6 sweep
        foreach (iops[o]) begin
            clear_mem();
            p = 0;
            load_operands(p);
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++) begin
                    imem[p++] = f_i(iops[o], 1 + i, 9, imms[j]);
                    imem[p++] = f_i(OP_STORE, 0, 9, 16'(64 + 4 * (i * 8 + j)));
                end
            run(p + 6);
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    chk((iops[o] >= OP_ANDI) ? "R6 zero-ext imm" : "R5 sign-ext imm",
                        dmem[16 + i * 8 + j], exp_i(iops[o], opnd[i], imms[j]));
        end
        // directed program: R7..R12 and the PC trace
        clear_mem();
        dmem[8] = 32'hCAFE_F00D;
        imem[0]  = f_i(OP_ADDIU, 0, 1, 16'd40);
        imem[1]  = f_i(OP_LOAD, 1, 2, 16'hFFF8);
        imem[2]  = f_i(OP_STORE, 1, 2, 16'd4);
        imem[3]  = f_r(FN_ADDU, 2, 2, 0);
        imem[4]  = f_i(OP_STORE, 0, 0, 16'd48);
        imem[5]  = f_i(OP_BEQ, 1, 2, 16'd1);
        imem[6]  = f_i(OP_ADDIU, 0, 3, 16'd7);
        imem[7]  = f_i(OP_BEQ, 3, 3, 16'd1);
        imem[8]  = f_i(OP_ADDIU, 0, 3, 16'd99);
        imem[9]  = f_i(OP_STORE, 0, 3, 16'd52);
        imem[10] = f_j(12);
        imem[11] = f_i(OP_ADDIU, 0, 3, 16'd55);
        imem[12] = f_i(OP_STORE, 0, 3, 16'd56);
        imem[13] = {6'h3F, 5'd0, 5'd3, 16'd80};
        imem[14] = f_r(6'h3E, 1, 1, 3);
        imem[15] = f_i(OP_STORE, 0, 3, 16'd60);
        imem[16] = f_i(OP_LOAD, 0, 0, 16'd32);
        imem[17] = f_i(OP_STORE, 0, 0, 16'd64);
        imem[18] = f_i(OP_STORE, 0, 2, 16'd68);
        run(24);
        chk("R7 load negative offset", dmem[11], 32'hCAFE_F00D);
        chk("R8 store address exact", dmem[10], 32'h5A5A_000A);
        chk("R8 store keeps rt", dmem[17], 32'hCAFE_F00D);
        chk("R11 write to r0 dropped", dmem[12], 32'd0);
        chk("R11 load to r0 dropped", dmem[16], 32'd0);
        chk("R9 branch skip", dmem[13], 32'd7);
        chk("R10 jump skip", dmem[14], 32'd7);
        chk("R12 undefined no reg write", dmem[15], 32'd7);
        chk("R12 undefined no store", dmem[20], 32'h5A5A_0014);
        begin
            int exp_idx [20] = '{0, 1, 2, 3, 4, 5, 6, 7, 9, 10,
                                 12, 13, 14, 15, 16, 17, 18, 19, 19, 19};
            for (int c = 0; c < 20; c++)
                chk((c == 8) ? "R9 taken target" : (c == 10) ? "R10 jump target" : "R2 pc sequence",
                    trace[c], 32'(exp_idx[c] * 4));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule